// File: doc/BRIEF.md
# Condensed Instruction Stream Decoder

This block sits behind the branch that enters a condensed subroutine. It takes the subroutine's code one byte at a time over a valid/ready handshake and turns it into decoded micro-operations for the operand-fetch and execute stages. Condensed code comes in two lengths. Long instructions take two bytes and name one of 256 typed operands. Short instructions take one byte and name a source register, and register zero is their implied destination. The decoder keeps track of which length is in force.

Opcode 1101 holds the control group. It switches the length, attaches a one-shot index register to the next instruction, and requests a return from the condensed block. It also provides a conditional loop-back whose condition is taken from the status bits. Two control encodings are two bytes long, and both are accepted in short mode with no prior switch to long mode. All control instructions except loop-back and the explicit short switch leave the decoder in long mode. An `enter` pulse marks entry into a new condensed subroutine.

Top module: `condensed_decoder`

## Requirements
- R1: After reset, and in the cycle after an `enter` pulse, the decoder is in long mode with no pending index register and no partly received instruction. `in_ready` is low only during reset and during `enter`.
- R2: In long mode every instruction is two bytes. Byte 0 carries the opcode in bits [7:4], the secondary-type flag in bit 3 and the destination register in bits [2:0]. Byte 1 is the operand number. A non-control opcode issues one micro-operation with `uop_short`=0, `uop_reg` set to the destination and `uop_operand` set to byte 1.
- R3: In short mode a non-control instruction is one byte with the same opcode and type positions, and bits [2:0] name the source register. It issues a micro-operation with `uop_short`=1 and `uop_operand`=0.
- R4: Byte 0 with bits [7:3]=11010 is a control instruction and issues no micro-operation. Field 101 selects short mode, field 100 selects long mode, and field 000 and the unassigned fields do nothing else.
- R5: In short mode, the encodings 11010010 (execute-next-indexed) and 11011xxx (loop-back) are still two bytes long, and their second byte is consumed as their operand. The other control encodings are one byte long.
- R6: Every control instruction other than loop-back and the short-mode select leaves the decoder in long mode.
- R7: Execute-next-indexed records bits [2:0] of its second byte as an index register. The next micro-operation carries it with `idx_valid`=1, and later micro-operations do not.
- R8: Loop-back byte 0 bits [2:0] form a mask {negative, zero, positive}. When the mask ANDed with `status` (same bit order, sampled as the offset byte is accepted) is non-zero, `loop_req` pulses with `loop_offset` equal to byte 1. Otherwise nothing is issued. The length mode is unchanged either way.
- R9: Field 111 pulses `ret_req` for one cycle.
- R10: All results appear in the cycle after the final byte is accepted, each as a one-cycle pulse, and at most one of `uop_valid`, `ret_req` and `loop_req` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enter | input | 1 | Start of a new condensed subroutine |
| in_valid | input | 1 | Instruction byte valid |
| in_data | input | 8 | Instruction byte |
| in_ready | output | 1 | Byte accepted when high with in_valid |
| status | input | 3 | Status bits {negative, zero, positive} |
| uop_valid | output | 1 | Micro-operation pulse |
| uop_opcode | output | 4 | Micro-operation opcode |
| uop_secondary | output | 1 | Secondary operand type selected |
| uop_short | output | 1 | Micro-operation came from a short instruction |
| uop_reg | output | 3 | Destination (long) or source (short) register |
| uop_operand | output | 8 | Operand number (long), zero for short |
| idx_valid | output | 1 | Index override applies to this micro-operation |
| idx_reg | output | 3 | Override index register |
| ret_req | output | 1 | Return from condensed block |
| loop_req | output | 1 | Loop-back taken |
| loop_offset | output | 8 | Loop-back distance in halfwords |
| mode_short | output | 1 | Short mode in force |

## Verification
Two functions can fall on the same instruction boundary. One is the length change made by a control instruction, which decides how the very next byte is framed. The other is the one-shot index, which must reach the next micro-operation after one or more control instructions. The bench provokes both with execute-next-indexed and loop-back sent in short mode, each followed directly by ordinary instructions. It judges the result in the scoreboard: a byte framed at the wrong length produces a micro-operation with the wrong fields, or an extra one, and a misplaced index shows up as a wrong `idx_valid` on the next micro-operation.

// File: rtl/cdec_pkg.sv
package cdec_pkg;
  localparam int BYTE_W = 8;
  localparam int OPC_W  = 4;
  localparam int FLD_W  = 3;
  localparam int STAT_W = 3;

  localparam logic [OPC_W-1:0] OPC_CTRL = 4'hD;

  typedef enum logic [FLD_W-1:0] {
    CF_NOP   = 3'b000,
    CF_XNX   = 3'b010,
    CF_LONG  = 3'b100,
    CF_SHORT = 3'b101,
    CF_RET   = 3'b111
  } ctrl_fld_e;

  typedef struct packed {
    logic [OPC_W-1:0] opc;
    logic             sec;
    logic [FLD_W-1:0] fld;
  } head_t;
endpackage

// File: rtl/cdec_classify.sv
module cdec_classify
  import cdec_pkg::*;
(
  input  logic [BYTE_W-1:0] head_byte,
  input  logic              short_mode,
  output logic              is_ctrl,
  output logic              two_byte
);
  head_t h;
  logic  wide_ctrl;

  always_comb begin
    h         = head_t'(head_byte);
    is_ctrl   = (h.opc == OPC_CTRL);
    wide_ctrl = is_ctrl && (h.sec || (h.fld == CF_XNX));
    two_byte  = !short_mode || wide_ctrl;
  end
endmodule

// File: rtl/cdec_exec.sv
module cdec_exec
  import cdec_pkg::*;
(
  input  logic [BYTE_W-1:0] head_byte,
  input  logic [BYTE_W-1:0] tail_byte,
  input  logic [STAT_W-1:0] status,
  input  logic              short_mode,
  output logic              do_uop,
  output logic              do_ret,
  output logic              do_loop,
  output logic              next_short,
  output logic              idx_set,
  output logic [FLD_W-1:0]  idx_set_reg
);
  head_t h;

  always_comb begin
    h           = head_t'(head_byte);
    do_uop      = 1'b0;
    do_ret      = 1'b0;
    do_loop     = 1'b0;
    next_short  = short_mode;
    idx_set     = 1'b0;
    idx_set_reg = tail_byte[FLD_W-1:0];
    if (h.opc != OPC_CTRL) begin
      do_uop = 1'b1;
    end else if (h.sec) begin
      do_loop = |(h.fld & status);
    end else begin
      next_short = 1'b0;
      case (h.fld)
        CF_XNX:   idx_set    = 1'b1;
        CF_SHORT: next_short = 1'b1;
        CF_RET:   do_ret     = 1'b1;
        default:  next_short = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/cdec_index.sv
module cdec_index
  import cdec_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             set,
  input  logic [FLD_W-1:0] set_reg,
  input  logic             consume,
  output logic             pend,
  output logic [FLD_W-1:0] pend_reg
);
  always_ff @(posedge clk) begin
    if (rst || clear) begin
      pend     <= 1'b0;
      pend_reg <= '0;
    end else if (set) begin
      pend     <= 1'b1;
      pend_reg <= set_reg;
    end else if (consume) begin
      pend     <= 1'b0;
      pend_reg <= '0;
    end
  end

  AST_IDX_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
    $past(consume) && !$past(set) |-> !pend); // R7
endmodule

// File: rtl/condensed_decoder.sv
module condensed_decoder
  import cdec_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              enter,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  output logic              in_ready,
  input  logic [STAT_W-1:0] status,
  output logic              uop_valid,
  output logic [OPC_W-1:0]  uop_opcode,
  output logic              uop_secondary,
  output logic              uop_short,
  output logic [FLD_W-1:0]  uop_reg,
  output logic [BYTE_W-1:0] uop_operand,
  output logic              idx_valid,
  output logic [FLD_W-1:0]  idx_reg,
  output logic              ret_req,
  output logic              loop_req,
  output logic [BYTE_W-1:0] loop_offset,
  output logic              mode_short
);
  logic              accept;
  logic              have_head;
  logic [BYTE_W-1:0] head_q;
  logic              cls_ctrl, cls_two;
  logic              finish;
  logic [BYTE_W-1:0] fin_head, fin_tail;
  logic              x_uop, x_ret, x_loop, x_short, x_idx_set;
  logic [FLD_W-1:0]  x_idx_reg;
  logic              pend;
  logic [FLD_W-1:0]  pend_reg;
  head_t             fh;

  assign in_ready = !rst && !enter;
  assign accept   = in_valid && in_ready;

  cdec_classify u_classify (
    .head_byte (in_data),
    .short_mode(mode_short),
    .is_ctrl   (cls_ctrl),
    .two_byte  (cls_two)
  );

  always_comb begin
    finish   = 1'b0;
    fin_head = in_data;
    fin_tail = '0;
    if (accept) begin
      if (have_head) begin
        finish   = 1'b1;
        fin_head = head_q;
        fin_tail = in_data;
      end else if (!cls_two) begin
        finish   = 1'b1;
      end
    end
    fh = head_t'(fin_head);
  end

  cdec_exec u_exec (
    .head_byte  (fin_head),
    .tail_byte  (fin_tail),
    .status     (status),
    .short_mode (mode_short),
    .do_uop     (x_uop),
    .do_ret     (x_ret),
    .do_loop    (x_loop),
    .next_short (x_short),
    .idx_set    (x_idx_set),
    .idx_set_reg(x_idx_reg)
  );

  cdec_index u_index (
    .clk     (clk),
    .rst     (rst),
    .clear   (enter),
    .set     (finish && x_idx_set),
    .set_reg (x_idx_reg),
    .consume (finish && x_uop),
    .pend    (pend),
    .pend_reg(pend_reg)
  );

  always_ff @(posedge clk) begin
    if (rst || enter) begin
      have_head <= 1'b0;
      head_q    <= '0;
      mode_short <= 1'b0;
    end else begin
      if (accept && !have_head && cls_two) begin
        have_head <= 1'b1;
        head_q    <= in_data;
      end else if (finish) begin
        have_head <= 1'b0;
      end
      if (finish) mode_short <= x_short;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || enter) begin
      uop_valid     <= 1'b0;
      uop_opcode    <= '0;
      uop_secondary <= 1'b0;
      uop_short     <= 1'b0;
      uop_reg       <= '0;
      uop_operand   <= '0;
      idx_valid     <= 1'b0;
      idx_reg       <= '0;
      ret_req       <= 1'b0;
      loop_req      <= 1'b0;
      loop_offset   <= '0;
    end else begin
      uop_valid <= finish && x_uop;
      ret_req   <= finish && x_ret;
      loop_req  <= finish && x_loop;
      if (finish && x_uop) begin
        uop_opcode    <= fh.opc;
        uop_secondary <= fh.sec;
        uop_short     <= mode_short;
        uop_reg       <= fh.fld;
        uop_operand   <= mode_short ? '0 : fin_tail;
        idx_valid     <= pend;
        idx_reg       <= pend ? pend_reg : '0;
      end else begin
        idx_valid     <= 1'b0;
      end
      if (finish && x_loop) loop_offset <= fin_tail;
    end
  end

  AST_ONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({uop_valid, ret_req, loop_req})); // R10
  AST_IDX_WITH_UOP: assert property (@(posedge clk) disable iff (rst)
    idx_valid |-> uop_valid); // R7
  AST_RET_LONG: assert property (@(posedge clk) disable iff (rst)
    ret_req |-> !mode_short); // R9
  AST_LOOP_KEEPS_MODE: assert property (@(posedge clk) disable iff (rst)
    loop_req |-> mode_short == $past(mode_short)); // R8
  AST_SHORT_NO_OPERAND: assert property (@(posedge clk) disable iff (rst)
    uop_valid && uop_short |-> uop_operand == '0); // R3
  AST_ENTER_LONG: assert property (@(posedge clk) disable iff (rst)
    $past(enter) |-> !mode_short && !pend); // R1
endmodule

// File: tb/test_condensed_decoder.sv
module test_condensed_decoder;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       enter = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_ready;
  logic [2:0] status = '0;
  logic       uop_valid, uop_secondary, uop_short, idx_valid, ret_req, loop_req, mode_short;
  logic [3:0] uop_opcode;
  logic [2:0] uop_reg, idx_reg;
  logic [7:0] uop_operand, loop_offset;

  int checks = 0;
  int errors = 0;
  logic [35:0] exp_q[$];
  string       tag_q[$];

  condensed_decoder i_condensed_decoder (
    .clk(clk), .rst(rst), .enter(enter), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .status(status), .uop_valid(uop_valid), .uop_opcode(uop_opcode),
    .uop_secondary(uop_secondary), .uop_short(uop_short), .uop_reg(uop_reg),
    .uop_operand(uop_operand), .idx_valid(idx_valid), .idx_reg(idx_reg),
    .ret_req(ret_req), .loop_req(loop_req), .loop_offset(loop_offset),
    .mode_short(mode_short)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // kind: 1 uop, 2 return, 3 loop-back
  function automatic logic [35:0] pack(input logic [1:0] kind, input logic [3:0] op,
      input logic sec, input logic sh, input logic [2:0] rg, input logic [7:0] opd,
      input logic iv, input logic [2:0] ir, input logic [7:0] off);
    return {kind, op, sec, sh, rg, opd, iv, ir, off, 3'b000};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic expect_uop(input string req, input logic [3:0] op, input logic sec,
      input logic sh, input logic [2:0] rg, input logic [7:0] opd, input logic iv,
      input logic [2:0] ir);
    exp_q.push_back(pack(2'd1, op, sec, sh, rg, opd, iv, ir, 8'h00));
    tag_q.push_back(req);
  endtask

  task automatic expect_ret(input string req);
    exp_q.push_back(pack(2'd2, 4'h0, 1'b0, 1'b0, 3'h0, 8'h00, 1'b0, 3'h0, 8'h00));
    tag_q.push_back(req);
  endtask

  task automatic expect_loop(input string req, input logic [7:0] off);
    exp_q.push_back(pack(2'd3, 4'h0, 1'b0, 1'b0, 3'h0, 8'h00, 1'b0, 3'h0, off));
    tag_q.push_back(req);
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
    @(posedge clk);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_enter();
    @(negedge clk);
    in_valid = 1'b0;
    enter = 1'b1;
    @(negedge clk);
    enter = 1'b0;
  endtask

  task automatic check_mode(input string req, input logic exp);
    check(mode_short === exp, req, "mode_short", {35'b0, mode_short}, {35'b0, exp});
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && (uop_valid || ret_req || loop_req)) begin
      logic [35:0] act;
      logic [35:0] exp;
      string tag;
      if ((uop_valid + ret_req + loop_req) > 1)
        act = '1;
      else if (uop_valid)
        act = pack(2'd1, uop_opcode, uop_secondary, uop_short, uop_reg, uop_operand,
                   idx_valid, idx_reg, 8'h00);
      else if (ret_req)
        act = pack(2'd2, 4'h0, 1'b0, 1'b0, 3'h0, 8'h00, 1'b0, 3'h0, 8'h00);
      else
        act = pack(2'd3, 4'h0, 1'b0, 1'b0, 3'h0, 8'h00, 1'b0, 3'h0, loop_offset);
      if (exp_q.size() == 0) begin
        check(1'b0, "R10", "unexpected result", act, '0);
      end else begin
        exp = exp_q.pop_front();
        tag = tag_q.pop_front();
        check(act === exp, tag, "result", act, exp);
      end
    end
  end

  initial begin : watchdog
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(in_ready === 1'b0, "R1", "ready in reset", {35'b0, in_ready}, 36'd0);
    rst = 1'b0;
    @(negedge clk);
    check_mode("R1", 1'b0);
    check(in_ready === 1'b1 && !uop_valid && !ret_req && !loop_req, "R1", "idle after reset",
          {32'b0, in_ready, uop_valid, ret_req, loop_req}, 36'h8);
    do_enter();

    // R2 long instructions
    expect_uop("R2", 4'h4, 1'b1, 1'b0, 3'd2, 8'h33, 1'b0, 3'd0);
    send(8'h4A); send(8'h33);
    expect_uop("R2", 4'h2, 1'b0, 1'b0, 3'd0, 8'h7F, 1'b0, 3'd0);
    send(8'h20); send(8'h7F);
    idle();

    // R4 switch to short
    send(8'hD5); send(8'h00);
    idle();
    check_mode("R4", 1'b1);

    // R3 short instructions
    expect_uop("R3", 4'h1, 1'b0, 1'b1, 3'd3, 8'h00, 1'b0, 3'd0);
    send(8'h13);
    expect_uop("R3", 4'hF, 1'b1, 1'b1, 3'd1, 8'h00, 1'b0, 3'd0);
    send(8'hF9);
    // R5 execute-next-indexed in short mode, two bytes, then long (R6)
    send(8'hD2); send(8'h0E);
    expect_uop("R7", 4'h6, 1'b0, 1'b0, 3'd0, 8'h11, 1'b1, 3'd6);
    send(8'h60); send(8'h11);
    expect_uop("R7", 4'h6, 1'b0, 1'b0, 3'd0, 8'h12, 1'b0, 3'd0);
    send(8'h60); send(8'h12);
    idle();
    check_mode("R6", 1'b0);

    // R8 loop-back in short mode
    send(8'hD5); send(8'h00);
    status = 3'b010;
    expect_loop("R8", 8'h20);
    send(8'hDA); send(8'h20);
    send(8'hDC); send(8'h05);      // mask negative only: not taken
    expect_uop("R5", 4'h5, 1'b0, 1'b1, 3'd1, 8'h00, 1'b0, 3'd0);
    send(8'h51);
    idle();
    check_mode("R8", 1'b1);

    // R9 return in short mode, one byte, forces long
    expect_ret("R9");
    send(8'hD7);
    expect_uop("R6", 4'h0, 1'b0, 1'b0, 3'd5, 8'h01, 1'b0, 3'd0);
    send(8'h05); send(8'h01);
    idle();
    check_mode("R9", 1'b0);

    // R4 no-op in short mode forces long; explicit long select
    send(8'hD5); send(8'h00);
    send(8'hD0);
    idle();
    check_mode("R6", 1'b0);
    send(8'hD4); send(8'h00);
    idle();
    check_mode("R4", 1'b0);

    // R1 enter drops pending index
    send(8'hD2); send(8'h05);
    idle();
    do_enter();
    expect_uop("R1", 4'h3, 1'b0, 1'b0, 3'd0, 8'h44, 1'b0, 3'd0);
    send(8'h30); send(8'h44);
    idle();

    // R1 enter from short mode
    send(8'hD5); send(8'h00);
    idle();
    check_mode("R4", 1'b1);
    do_enter();
    check_mode("R1", 1'b0);

    // R8 full mask in long mode, positive status
    status = 3'b001;
    expect_loop("R8", 8'h80);
    send(8'hDF); send(8'h80);
    idle();
    check_mode("R8", 1'b0);

    // R7 index survives an intervening control instruction
    send(8'hD2); send(8'hFB);
    send(8'hD0); send(8'h00);
    expect_uop("R7", 4'hA, 1'b1, 1'b0, 3'd7, 8'hC3, 1'b1, 3'd3);
    send(8'hAF); send(8'hC3);
    idle();
    idle();

    check(exp_q.size() == 0, "R10", "missing results", 36'(exp_q.size()), 36'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule